// File: doc/BRIEF.md
# Non-Maskable Interrupt Edge Detector and Acceptance Gate

This block watches an asynchronous non-maskable interrupt pin. It detects the edge direction chosen by a polarity control, and for each detected edge it decides whether the request is taken. An accepted edge sets a pending flag that carries the fixed top priority level, 16, which ranks above every other interrupt source. The flag stays set until the CPU acknowledges it. When the edge is accepted in standby, the block also raises a one-cycle wake-up pulse.

Acceptance depends on four control inputs: a global disable, the CPU block bit, a block-mask override and the current power mode. Any change to the polarity control starts a blanking window. The pin may look like it toggles while the comparison reference switches, and the window keeps that from being taken as a request. An edge that lands inside the window is dropped for good. It is not held over until the window ends. The block does not touch the CPU interrupt mask level: its only outputs are the request, its level and the wake pulse.

Top module: `nmi_gate`

## Requirements
- R1: After reset, req_pend is 0, req_level is 0 and wake is 0. The internal polarity reference resets to rising.
- R2: The pin passes through a two-stage synchroniser. For an accepted edge, req_pend goes high at the third rising clock edge after the pin changes.
- R3: With pol_rise=1, only a 0-to-1 pin transition is detected. With pol_rise=0, only a 1-to-0 transition is detected. The opposite transition has no effect on req_pend.
- R4: req_level is 16 (5'b10000) while req_pend is 1, and 0 otherwise.
- R5: req_pend stays 1 until ack is sampled high, and clears at that edge. If a new accepted edge arrives in the same cycle as ack, req_pend stays 1.
- R6: A change of pol_rise is seen at a clock edge, which starts the blanking window. Edges evaluated at that edge and at the next 20 edges are discarded permanently. An edge evaluated at the 21st edge after the change is accepted.
- R7: While nmi_off is 1, no edge is accepted in any power mode.
- R8: pwr_mode uses 2'b00 for run, 2'b01 for sleep and 2'b10 for standby (2'b11 acts as sleep). With nmi_off=0 in run mode, an edge is accepted when blk is 0 or blk_mask is 1. In any non-run mode, an edge is accepted whatever blk is.
- R9: An edge accepted while pwr_mode is 2'b10 makes wake high for exactly one cycle, in the same cycle that req_pend rises. There is no wake pulse in the other modes, and none while nmi_off is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Asynchronous interrupt pin |
| pol_rise | input | 1 | 1 selects rising edges, 0 selects falling edges |
| blk | input | 1 | CPU block bit |
| blk_mask | input | 1 | Lets the request through while blk is set |
| nmi_off | input | 1 | Global disable |
| pwr_mode | input | 2 | Power mode (00 run, 01 sleep, 10 standby) |
| ack | input | 1 | One-cycle acknowledge that clears the pending flag |
| req_pend | output | 1 | Pending request |
| req_level | output | 5 | Priority of the pending request |
| wake | output | 1 | One-cycle wake-up pulse |

## Verification
Rising and falling pin transitions are applied under both polarities, which separates a correct edge selection from level sensing and from detecting both edges. Polarity flips are followed by pin edges placed on the last blanked cycle and on the first open cycle, which pins down the window length and shows that a blanked edge is dropped and not deferred. The same pin edge is replayed across every combination of block bit, mask override, global disable and power mode, so the acceptance rule and the standby-only wake pulse are each checked. An acknowledge that coincides with a fresh edge shows that setting the flag wins over clearing it.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
    localparam int NMI_LEVEL = 16;
    localparam int NMI_LW    = $clog2(NMI_LEVEL + 1);

    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_SLEEP = 2'b01,
        PM_STBY  = 2'b10,
        PM_RSVD  = 2'b11
    } pwr_mode_e;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/nmi_edge.sv
module nmi_edge #(
    parameter int BLANK_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic pol_in,
    output logic hit
);
    localparam int CW = $clog2(BLANK_CYC + 1);

    typedef struct packed {
        logic          prev;
        logic          pol;
        logic [CW-1:0] cnt;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     pol_chg;
    logic     match;

    always_comb begin
        st_d    = st_q;
        pol_chg = (pol_in != st_q.pol);
        match   = (pin_s != st_q.prev) && (pin_s == st_q.pol);
        hit     = match && !pol_chg && (st_q.cnt == '0);

        st_d.prev = pin_s;
        st_d.pol  = pol_in;
        if (pol_chg)
            st_d.cnt = CW'(BLANK_CYC);
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= 1'b0;
            st_q.pol  <= 1'b1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/nmi_accept.sv
module nmi_accept
    import nmi_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  logic      off,
    input  logic      blk,
    input  logic      bmask,
    input  pwr_mode_e mode,
    input  logic      ack,
    output logic      pend,
    output logic      wake
);
    typedef struct packed {
        logic pend;
        logic wake;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic    lowpwr;
    logic    take;

    always_comb begin
        lowpwr    = (mode != PM_RUN);
        take      = hit && !off && (!blk || bmask || lowpwr);
        st_d.pend = take || (st_q.pend && !ack);
        st_d.wake = take && (mode == PM_STBY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign wake = st_q.wake;
endmodule

// File: rtl/nmi_gate.sv
module nmi_gate
    import nmi_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BLANK_CYC   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_pin,
    input  logic              pol_rise,
    input  logic              blk,
    input  logic              blk_mask,
    input  logic              nmi_off,
    input  logic [1:0]        pwr_mode,
    input  logic              ack,
    output logic              req_pend,
    output logic [NMI_LW-1:0] req_level,
    output logic              wake
);
    logic pin_s;
    logic hit;

    nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (nmi_pin),
        .dout (pin_s)
    );

    nmi_edge #(.BLANK_CYC(BLANK_CYC)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_s (pin_s),
        .pol_in(pol_rise),
        .hit   (hit)
    );

    nmi_accept u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .hit  (hit),
        .off  (nmi_off),
        .blk  (blk),
        .bmask(blk_mask),
        .mode (pwr_mode_e'(pwr_mode)),
        .ack  (ack),
        .pend (req_pend),
        .wake (wake)
    );

    assign req_level = req_pend ? NMI_LW'(NMI_LEVEL) : '0;
endmodule

// File: rtl/nmi_gate_chk.sv
module nmi_gate_chk
    import nmi_pkg::*;
#(
    parameter int BLANK_CYC = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pol_rise,
    input logic              nmi_off,
    input logic [1:0]        pwr_mode,
    input logic              ack,
    input logic              req_pend,
    input logic [NMI_LW-1:0] req_level,
    input logic              wake
);
    localparam int CW = $clog2(BLANK_CYC + 1);

    logic          pol_seen;
    logic [CW-1:0] win_cnt;
    logic          pol_flip;

    assign pol_flip = (pol_rise != pol_seen);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_seen <= 1'b1;
            win_cnt  <= '0;
        end else begin
            pol_seen <= pol_rise;
            if (pol_flip)            win_cnt <= CW'(BLANK_CYC);
            else if (win_cnt != '0)  win_cnt <= win_cnt - 1'b1;
        end
    end

    // R4
    level_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_pend |-> (req_level == NMI_LW'(NMI_LEVEL)));

    // R4
    level_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_pend |-> (req_level == '0));

    // R5
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pend && !ack) |=> req_pend);

    // R9
    wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    // R9
    wake_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (req_pend && $past(pwr_mode) == 2'b10));

    // R7
    off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_pend) |-> !$past(nmi_off));

    // R6
    blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_pend) |-> ($past(win_cnt) == '0 && !$past(pol_flip)));
endmodule

bind nmi_gate nmi_gate_chk #(.BLANK_CYC(BLANK_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pol_rise (pol_rise),
    .nmi_off  (nmi_off),
    .pwr_mode (pwr_mode),
    .ack      (ack),
    .req_pend (req_pend),
    .req_level(req_level),
    .wake     (wake)
);

// File: tb/sim_nmi_gate.sv
`timescale 1ns/1ps
module sim_nmi_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_pin = 1'b0;
    logic       pol_rise = 1'b1;
    logic       blk = 1'b0;
    logic       blk_mask = 1'b0;
    logic       nmi_off = 1'b0;
    logic [1:0] pwr_mode = 2'b00;
    logic       ack = 1'b0;
    logic       req_pend;
    logic [4:0] req_level;
    logic       wake;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    nmi_gate u0 (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .pol_rise(pol_rise),
        .blk(blk), .blk_mask(blk_mask), .nmi_off(nmi_off), .pwr_mode(pwr_mode),
        .ack(ack), .req_pend(req_pend), .req_level(req_level), .wake(wake)
    );

    // behavioural reference model
    bit q_pin[$];
    bit m_s2, m_prev, m_pol, m_pend, m_wake;
    int m_blank;

    always @(posedge clk) begin
        if (!rst_n) begin
            q_pin = {1'b0};
            m_s2 = 0; m_prev = 0; m_pol = 1; m_blank = 0;
            m_pend = 0; m_wake = 0;
        end else begin
            bit chg, edge_ok, take;
            chg     = (pol_rise != m_pol);
            edge_ok = !chg && (m_blank == 0) && (m_s2 != m_prev) && (m_s2 == m_pol);
            take    = edge_ok && !nmi_off && (!blk || blk_mask || pwr_mode != 2'b00);
            m_pend  = take || (m_pend && !ack);
            m_wake  = take && (pwr_mode == 2'b10);
            if (chg) m_blank = 20;
            else if (m_blank > 0) m_blank = m_blank - 1;
            m_pol  = pol_rise;
            m_prev = m_s2;
            m_s2   = q_pin.pop_front();
            q_pin.push_back(nmi_pin);
        end
    end

    task automatic cmp(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            cmp({cur_req, " pend"}, int'(req_pend), int'(m_pend));
            cmp({cur_req, " level"}, int'(req_level), m_pend ? 16 : 0);
            cmp({cur_req, " wake"}, int'(wake), int'(m_wake));
        end
        if (cyc > 5000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <5000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_ack();
        ack = 1'b1; tick(1); ack = 1'b0;
    endtask

    // drive a full pin pulse matching the current polarity and return to rest
    task automatic fire(string req, int exp_pend, int exp_wake);
        cur_req = req;
        nmi_pin = ~nmi_pin;
        tick(3);
        cmp({req, " named pend"}, int'(req_pend), exp_pend);
        cmp({req, " named wake"}, int'(wake), exp_wake);
        tick(1);
        cmp({req, " wake gone"}, int'(wake), 0);
        nmi_pin = ~nmi_pin;
        tick(4);
        if (req_pend) pulse_ack();
        tick(2);
    endtask

    initial begin
        tick(3);
        cmp("R1 reset pend", int'(req_pend), 0);
        cmp("R1 reset level", int'(req_level), 0);
        cmp("R1 reset wake", int'(wake), 0);
        rst_n = 1'b1;
        tick(2);

        // R2/R3/R4 rising edge, run mode
        cur_req = "R2";
        nmi_pin = 1'b1;
        tick(2);
        cmp("R2 not yet", int'(req_pend), 0);
        tick(1);
        cmp("R2 pend at third edge", int'(req_pend), 1);
        cmp("R4 level 16", int'(req_level), 16);
        tick(3);
        cmp("R5 held", int'(req_pend), 1);
        cur_req = "R5";
        pulse_ack();
        cmp("R5 cleared", int'(req_pend), 0);
        cmp("R4 level 0", int'(req_level), 0);
        // R3 falling under rising polarity: ignored
        cur_req = "R3";
        nmi_pin = 1'b0;
        tick(6);
        cmp("R3 fall ignored", int'(req_pend), 0);

        // R6 polarity change; edge on last blanked edge discarded
        cur_req = "R6";
        nmi_pin = 1'b1; tick(4); pulse_ack(); tick(2);
        pol_rise = 1'b0;
        tick(18);
        nmi_pin = 1'b0;
        tick(5);
        cmp("R6 blanked discarded", int'(req_pend), 0);
        tick(20);
        cmp("R6 not deferred", int'(req_pend), 0);
        // R3 falling with falling polarity (rising first is ignored)
        cur_req = "R3";
        nmi_pin = 1'b1; tick(5);
        cmp("R3 rise ignored", int'(req_pend), 0);
        nmi_pin = 1'b0; tick(3);
        cmp("R3 fall accepted", int'(req_pend), 1);
        pulse_ack(); tick(2);
        // R6 first open edge accepted
        cur_req = "R6";
        pol_rise = 1'b1;
        tick(19);
        nmi_pin = 1'b1;
        tick(4);
        cmp("R6 first open edge", int'(req_pend), 1);
        pulse_ack(); nmi_pin = 1'b0; tick(4);

        // R7 global disable in every mode
        nmi_off = 1'b1;
        for (int m = 0; m < 4; m++) begin
            pwr_mode = 2'(m);
            fire("R7", 0, 0);
        end
        nmi_off = 1'b0;

        // R8 acceptance matrix
        pwr_mode = 2'b00; blk = 1'b1; blk_mask = 1'b0;
        fire("R8", 0, 0);
        blk_mask = 1'b1;
        fire("R8", 1, 0);
        blk_mask = 1'b0; pwr_mode = 2'b01;
        fire("R8", 1, 0);
        pwr_mode = 2'b11;
        fire("R8", 1, 0);
        // R9 standby wake even with blk set
        pwr_mode = 2'b10;
        fire("R9", 1, 1);
        blk = 1'b0;
        fire("R9", 1, 1);
        pwr_mode = 2'b00;
        fire("R9", 1, 0);

        // R5 ack coinciding with new edge keeps pending
        cur_req = "R5";
        nmi_pin = 1'b1; tick(4);
        nmi_pin = 1'b0; tick(2);
        nmi_pin = 1'b1; tick(2);
        ack = 1'b1; tick(1); ack = 1'b0;
        cmp("R5 set wins over ack", int'(req_pend), 1);
        pulse_ack();
        cmp("R5 cleared after", int'(req_pend), 0);
        tick(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule